// File: doc/BRIEF.md
# Dual-Path Control Register Bank

This block holds a small set of 64-bit control and status registers that two masters can reach. A privileged configuration path picks a register directly by word index (byte address shifted right by three). A memory-mapped path uses the same register file, but its word index is moved up by a fixed base of 0x0A. Its byte address 0 therefore lands on the window base register. The block accepts only full 8-byte accesses. A byte address whose low three bits are not zero counts as invalid.

The registers are:
- A fault register, which has alias indices for AND and OR updates.
- A control register, which has alias indices for bit-set and bit-clear updates.
- A window base register with an enable bit. It compares an incoming physical address against its stored bits to produce a window-hit level.
- A secondary base register.
- Plain storage words: a mask word, a DMA upper-address word and two action words.
- A read-only interrupt status word that follows the external status sources.

Both request ports use valid/ready and carry one access per cycle. The configuration path is always ready. The memory-mapped path is held off with ready low in any cycle where the configuration path presents a request, so a master on that path must keep its request stable until ready is high. A read returns its data on the response port exactly one cycle after acceptance. The response cannot be stalled. A write gives no response. It raises a one-cycle error pulse when the write is rejected.

Top module: `dual_path_regbank`

## Requirements
- R1: The configuration path addresses register index = byte address >> 3. The memory-mapped path addresses index = (byte address >> 3) + 0x0A. Memory-mapped byte address 0x00 reaches the window base register and 0x20 reaches the control register.
- R2: A write to index 0x01 ANDs the data into the fault register at index 0x00. A write to index 0x02 ORs the data into it. A write to 0x00 replaces it.
- R3: A write to index 0x12 ORs the data into the control register at 0x0E. A write to 0x13 clears the control bits that are set in the data. A write to 0x0E replaces the value.
- R4: A configuration write to the window base register at 0x0A keeps only the bits of 0x0003fffffff00000 plus enable bit 0. A memory-mapped write to 0x0A leaves it unchanged and pulses the error output.
- R5: A write to the secondary base register at 0x0B keeps only the bits of 0x0003ffff00000000.
- R6: A read of an unimplemented index returns all ones. This includes the alias indices 0x01, 0x02, 0x12 and 0x13 and any index beyond the bank. A write to an unimplemented index changes no register and pulses the error output.
- R7: The status register at 0x15 reads the NSRC status inputs in bits 32 upward, sampled one cycle earlier. A write to it changes nothing and pulses the error output.
- R8: Indices 0x00, 0x06, 0x07, 0x0F and 0x14 store and return the full 64-bit written value.
- R9: An access whose byte address has any of bits [2:0] set is invalid. A read returns all ones. A write changes no register and pulses the error output.
- R10: win_hit is high only when base bit 0 is set and probe_addr masked by 0x0003fffffff00000 equals the stored base bits under the same mask.
- R11: cfg_ready is always high. mm_ready is low whenever cfg_valid is high. An accepted read raises rsp_valid with its data in the next cycle, and rsp_valid is never high otherwise. An accepted write pulses err one cycle later only if it is rejected.
- R12: After reset every register reads zero, win_hit is low, and err and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration-path request valid |
| cfg_ready | output | 1 | Configuration-path request ready (always 1) |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | ADDR_W | Configuration-path byte address |
| cfg_wdata | input | 64 | Configuration-path write data |
| mm_valid | input | 1 | Memory-mapped request valid |
| mm_ready | output | 1 | Memory-mapped request ready |
| mm_write | input | 1 | 1 = write, 0 = read |
| mm_addr | input | ADDR_W | Memory-mapped byte address, offset inside the window |
| mm_wdata | input | 64 | Memory-mapped write data |
| stat_in | input | NSRC | Interrupt status source levels |
| probe_addr | input | 64 | Physical address compared against the window base |
| win_hit | output | 1 | Probe address falls in the enabled window |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| err | output | 1 | One-cycle pulse on a rejected write |

## Verification
The alias updates are tried with data patterns that overlap the stored value only in part. This separates AND from OR from replace, and clear from set. The base and secondary base registers are written with all ones, so any mask bit that is wrong shows in the read-back. The same bit positions are also reached through the memory-mapped offset, which separates the two path translations. Simultaneous requests on both paths show the priority and the stall. Misaligned, unimplemented, out-of-range and read-only accesses are each followed by a read of the register they could have disturbed. The window compare is probed at a matching address, at an address that differs only above the 1 MiB granule, and with the enable cleared.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned DW           = 64;
  localparam int unsigned MM_IDX_BASE  = 'h0A;
  localparam int unsigned IX_FAULT     = 'h00;
  localparam int unsigned IX_FAULT_AND = 'h01;
  localparam int unsigned IX_FAULT_OR  = 'h02;
  localparam int unsigned IX_ACT0      = 'h06;
  localparam int unsigned IX_ACT1      = 'h07;
  localparam int unsigned IX_WBASE     = 'h0A;
  localparam int unsigned IX_SBASE     = 'h0B;
  localparam int unsigned IX_CTRL      = 'h0E;
  localparam int unsigned IX_MASK      = 'h0F;
  localparam int unsigned IX_CTRL_SET  = 'h12;
  localparam int unsigned IX_CTRL_CLR  = 'h13;
  localparam int unsigned IX_DMAUP     = 'h14;
  localparam int unsigned IX_STAT      = 'h15;
  localparam logic [DW-1:0] WBASE_MASK = 64'h0003_ffff_fff0_0000;
  localparam logic [DW-1:0] SBASE_MASK = 64'h0003_ffff_0000_0000;
  localparam int unsigned STAT_LSB     = 32;

  typedef struct packed {
    logic          valid;
    logic          write;
    logic          from_mm;
    logic          aligned;
    logic [31:0]   idx;
    logic [DW-1:0] wdata;
  } access_t;
endpackage

// File: rtl/regbank_arb.sv
module regbank_arb
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              mm_valid,
  input  logic              mm_write,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [DW-1:0]     mm_wdata,
  output logic              mm_ready,
  output access_t           acc
);
  localparam int unsigned WORD_W = ADDR_W - 3;

  logic [31:0] cfg_idx, mm_idx;
  assign cfg_idx  = 32'(cfg_addr[ADDR_W-1:3]);
  assign mm_idx   = 32'(mm_addr[ADDR_W-1:3]) + MM_IDX_BASE;
  assign mm_ready = !cfg_valid;

  always_comb begin
    acc = '0;
    if (cfg_valid) begin
      acc.valid   = 1'b1;
      acc.write   = cfg_write;
      acc.aligned = (cfg_addr[2:0] == 3'b000);
      acc.idx     = cfg_idx;
      acc.wdata   = cfg_wdata;
    end else if (mm_valid) begin
      acc.valid   = 1'b1;
      acc.write   = mm_write;
      acc.from_mm = 1'b1;
      acc.aligned = (mm_addr[2:0] == 3'b000);
      acc.idx     = mm_idx;
      acc.wdata   = mm_wdata;
    end
  end

  logic unused_w;
  assign unused_w = (WORD_W == 0);
endmodule

// File: rtl/regbank_regs.sv
module regbank_regs
  import regbank_pkg::*;
#(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  access_t         acc,
  input  logic [NSRC-1:0] stat_in,
  output logic [DW-1:0]   wbase,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            err
);
  logic [DW-1:0] fault_q, act0_q, act1_q, wbase_q, sbase_q, ctrl_q, mask_q, dmaup_q;
  logic [NSRC-1:0] stat_q;
  logic [DW-1:0] stat_word, rd_word;
  logic wr_ok, wr_known, wr_reject, rd_acc;

  assign stat_word = 64'(stat_q) << STAT_LSB;
  assign wbase     = wbase_q;

  always_comb begin
    case (acc.idx)
      IX_FAULT, IX_FAULT_AND, IX_FAULT_OR, IX_ACT0, IX_ACT1, IX_SBASE,
      IX_CTRL, IX_MASK, IX_CTRL_SET, IX_CTRL_CLR, IX_DMAUP: wr_known = 1'b1;
      IX_WBASE: wr_known = !acc.from_mm;
      default:  wr_known = 1'b0;
    endcase
  end

  assign wr_ok     = acc.valid && acc.write && acc.aligned && wr_known;
  assign wr_reject = acc.valid && acc.write && !(acc.aligned && wr_known);
  assign rd_acc    = acc.valid && !acc.write;

  always_comb begin
    rd_word = '1;
    if (acc.aligned) begin
      case (acc.idx)
        IX_FAULT: rd_word = fault_q;
        IX_ACT0:  rd_word = act0_q;
        IX_ACT1:  rd_word = act1_q;
        IX_WBASE: rd_word = wbase_q;
        IX_SBASE: rd_word = sbase_q;
        IX_CTRL:  rd_word = ctrl_q;
        IX_MASK:  rd_word = mask_q;
        IX_DMAUP: rd_word = dmaup_q;
        IX_STAT:  rd_word = stat_word;
        default:  rd_word = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= '0; act0_q <= '0; act1_q <= '0; wbase_q <= '0;
      sbase_q <= '0; ctrl_q <= '0; mask_q <= '0; dmaup_q <= '0;
      stat_q <= '0; rsp_valid <= 1'b0; rsp_rdata <= '0; err <= 1'b0;
    end else begin
      stat_q    <= stat_in;
      rsp_valid <= rd_acc;
      rsp_rdata <= rd_acc ? rd_word : '0;
      err       <= wr_reject;
      if (wr_ok) begin
        case (acc.idx)
          IX_FAULT:     fault_q <= acc.wdata;
          IX_FAULT_AND: fault_q <= fault_q & acc.wdata;
          IX_FAULT_OR:  fault_q <= fault_q | acc.wdata;
          IX_ACT0:      act0_q  <= acc.wdata;
          IX_ACT1:      act1_q  <= acc.wdata;
          IX_WBASE:     wbase_q <= acc.wdata & (WBASE_MASK | 64'h1);
          IX_SBASE:     sbase_q <= acc.wdata & SBASE_MASK;
          IX_CTRL:      ctrl_q  <= acc.wdata;
          IX_MASK:      mask_q  <= acc.wdata;
          IX_CTRL_SET:  ctrl_q  <= ctrl_q | acc.wdata;
          IX_CTRL_CLR:  ctrl_q  <= ctrl_q & ~acc.wdata;
          IX_DMAUP:     dmaup_q <= acc.wdata;
          default: ;
        endcase
      end
    end
  end

  a_r4_mm_base_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.valid && acc.write && acc.from_mm && acc.idx == IX_WBASE) |=> (wbase_q == $past(wbase_q) && err));
  a_r4_base_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wbase_q & ~(WBASE_MASK | 64'h1)) == '0);
  a_r11_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.valid && !acc.write) |=> rsp_valid);
  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.valid && acc.write) |=> !rsp_valid);
  a_r7_status_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.valid && acc.write && acc.idx == IX_STAT) |=> err);
  a_r9_misaligned_keeps_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.valid && acc.write && !acc.aligned) |=> $stable(fault_q) && $stable(ctrl_q));
endmodule

// File: rtl/regbank_window.sv
module regbank_window
  import regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wbase,
  input  logic [DW-1:0] probe_addr,
  output logic          win_hit
);
  assign win_hit = wbase[0] && ((probe_addr & WBASE_MASK) == (wbase & WBASE_MASK));

  a_r10_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> wbase[0]);
endmodule

// File: rtl/dual_path_regbank.sv
module dual_path_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned NSRC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_write,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [63:0]       cfg_wdata,
  input  logic              mm_valid,
  output logic              mm_ready,
  input  logic              mm_write,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [63:0]       mm_wdata,
  input  logic [NSRC-1:0]   stat_in,
  input  logic [63:0]       probe_addr,
  output logic              win_hit,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              err
);
  access_t       acc;
  logic [DW-1:0] wbase;

  assign cfg_ready = 1'b1;

  regbank_arb #(.ADDR_W(ADDR_W)) u_arb (
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mm_valid(mm_valid), .mm_write(mm_write), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_ready(mm_ready), .acc(acc));

  regbank_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .stat_in(stat_in), .wbase(wbase),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err(err));

  regbank_window u_win (
    .clk(clk), .rst_n(rst_n), .wbase(wbase), .probe_addr(probe_addr), .win_hit(win_hit));

  a_r11_mm_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !mm_ready);
endmodule

// File: tb/dual_path_regbank_tb.sv
module dual_path_regbank_tb;
  localparam int ADDR_W = 9;
  localparam int NSRC   = 5;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, cfg_write = 0, mm_valid = 0, mm_write = 0;
  logic cfg_ready, mm_ready, win_hit, rsp_valid, err;
  logic [ADDR_W-1:0] cfg_addr = '0, mm_addr = '0;
  logic [63:0] cfg_wdata = '0, mm_wdata = '0, probe_addr = '0, rsp_rdata;
  logic [NSRC-1:0] stat_in = '0;

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  dual_path_regbank #(.ADDR_W(ADDR_W), .NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_write(cfg_write), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mm_valid(mm_valid), .mm_ready(mm_ready), .mm_write(mm_write), .mm_addr(mm_addr),
    .mm_wdata(mm_wdata), .stat_in(stat_in), .probe_addr(probe_addr), .win_hit(win_hit),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err(err));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected response", rsp_rdata, 64'hx);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic cfg_wr(int unsigned addr, logic [63:0] d, logic exp_err, string req);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 1; cfg_addr = ADDR_W'(addr); cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 0; cfg_write = 0;
    check(req, 64'(err), 64'(exp_err));
  endtask

  task automatic mm_wr(int unsigned addr, logic [63:0] d, logic exp_err, string req);
    @(negedge clk);
    mm_valid = 1; mm_write = 1; mm_addr = ADDR_W'(addr); mm_wdata = d;
    @(negedge clk);
    mm_valid = 0; mm_write = 0;
    check(req, 64'(err), 64'(exp_err));
  endtask

  task automatic cfg_rd(int unsigned addr, logic [63:0] exp, string req);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 0; cfg_addr = ADDR_W'(addr);
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic mm_rd(int unsigned addr, logic [63:0] exp, string req);
    @(negedge clk);
    mm_valid = 1; mm_write = 0; mm_addr = ADDR_W'(addr);
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    mm_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    check("R12 win_hit", 64'(win_hit), 0);
    check("R12 err", 64'(err), 0);
    check("R12 rsp_valid", 64'(rsp_valid), 0);
    check("R11 cfg_ready", 64'(cfg_ready), 1);
    cfg_rd('h00 << 3, 0, "R12 fault reset");
    cfg_rd('h0A << 3, 0, "R12 base reset");
    cfg_rd('h0E << 3, 0, "R12 ctrl reset");
    // R8 plain storage on both paths
    cfg_wr('h06 << 3, 64'hA5A5_0123_4567_89AB, 0, "R8 write act0");
    cfg_rd('h06 << 3, 64'hA5A5_0123_4567_89AB, "R8 act0");
    mm_wr(('h14 - 'h0A) << 3, 64'hDEAD_BEEF_0000_1111, 0, "R1 mm write dma");
    cfg_rd('h14 << 3, 64'hDEAD_BEEF_0000_1111, "R1 R8 dma via cfg");
    cfg_wr('h0F << 3, 64'h0F0F_0F0F_0F0F_0F0F, 0, "R8 write mask");
    mm_rd(('h0F - 'h0A) << 3, 64'h0F0F_0F0F_0F0F_0F0F, "R1 R8 mask via mm");
    // R2 fault aliases
    cfg_wr('h00 << 3, 64'hF0F0_F0F0_F0F0_F0F0, 0, "R2 fault write");
    cfg_wr('h01 << 3, 64'hFF00_FF00_FF00_FF00, 0, "R2 fault and");
    cfg_rd('h00 << 3, 64'hF000_F000_F000_F000, "R2 after and");
    cfg_wr('h02 << 3, 64'h0000_0000_0000_000F, 0, "R2 fault or");
    cfg_rd('h00 << 3, 64'hF000_F000_F000_F00F, "R2 after or");
    // R3 control set/clear
    cfg_wr('h0E << 3, 64'h8000_0000_0000_0001, 0, "R3 ctrl write");
    cfg_wr('h12 << 3, 64'h4000_0000_0000_0002, 0, "R3 ctrl set");
    mm_rd(('h0E - 'h0A) << 3, 64'hC000_0000_0000_0003, "R1 R3 after set");
    cfg_wr('h13 << 3, 64'h8000_0000_0000_0001, 0, "R3 ctrl clear");
    cfg_rd('h0E << 3, 64'h4000_0000_0000_0002, "R3 after clear");
    // R4 base register
    cfg_wr('h0A << 3, ONES, 0, "R4 base write");
    mm_rd(0, 64'h0003_ffff_fff0_0001, "R1 R4 base masked");
    mm_wr(0, 64'h0000_0000_1230_0001, 1, "R4 mm base write err");
    cfg_rd('h0A << 3, 64'h0003_ffff_fff0_0001, "R4 base unchanged");
    // R5 secondary base
    cfg_wr('h0B << 3, ONES, 0, "R5 sbase write");
    cfg_rd('h0B << 3, 64'h0003_ffff_0000_0000, "R5 sbase masked");
    // R10 window hit
    cfg_wr('h0A << 3, 64'h0000_0001_2340_0001, 0, "R10 base set");
    probe_addr = 64'h0000_0001_2345_6789; #1;
    check("R10 hit", 64'(win_hit), 1);
    probe_addr = 64'h0000_0001_2440_0000; #1;
    check("R10 miss", 64'(win_hit), 0);
    probe_addr = 64'h0000_0001_2345_6789;
    cfg_wr('h0A << 3, 64'h0000_0001_2340_0000, 0, "R10 disable");
    check("R10 disabled", 64'(win_hit), 0);
    // R6 unimplemented
    cfg_rd('h03 << 3, ONES, "R6 read 0x03");
    cfg_rd('h13 << 3, ONES, "R6 read alias");
    mm_rd(63 << 3, ONES, "R6 mm out of range");
    cfg_wr('h03 << 3, 64'h1234, 1, "R6 write 0x03 err");
    cfg_rd('h03 << 3, ONES, "R6 still ones");
    // R7 status
    stat_in = 5'b10101;
    repeat (2) @(negedge clk);
    cfg_rd('h15 << 3, 64'h0000_0015_0000_0000, "R7 status");
    cfg_wr('h15 << 3, 64'h0, 1, "R7 status write err");
    cfg_rd('h15 << 3, 64'h0000_0015_0000_0000, "R7 status kept");
    // R9 misaligned
    cfg_rd(('h06 << 3) | 1, ONES, "R9 misaligned read");
    cfg_wr(('h06 << 3) | 4, 64'h0, 1, "R9 misaligned write err");
    cfg_rd('h06 << 3, 64'hA5A5_0123_4567_89AB, "R9 act0 kept");
    // R11 arbitration: both paths at once
    @(negedge clk);
    cfg_valid = 1; cfg_write = 0; cfg_addr = ADDR_W'('h06 << 3);
    mm_valid = 1; mm_write = 0; mm_addr = ADDR_W'(('h14 - 'h0A) << 3);
    exp_q.push_back(64'hA5A5_0123_4567_89AB); tag_q.push_back("R11 cfg first");
    #1 check("R11 mm stalled", 64'(mm_ready), 0);
    @(negedge clk);
    cfg_valid = 0;
    exp_q.push_back(64'hDEAD_BEEF_0000_1111); tag_q.push_back("R11 mm second");
    #1 check("R11 mm ready", 64'(mm_ready), 1);
    @(negedge clk);
    mm_valid = 0;
    repeat (3) @(negedge clk);
    check("R11 scoreboard drained", 64'(exp_q.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule